// File: doc/BRIEF.md
# Nibble-Granular Sample Buffer

This block is the data buffer of one audio sample channel. It holds 128 bytes in a ring, and every access moves through it in 4-bit steps. Inside a byte the upper nibble always goes in and comes out before the lower one. A host port moves whole bytes, two nibbles per strobe. A sample-engine port moves one, two or four nibbles per request, with the first nibble stored being the most significant one of the value.

The channel mode fixes which side writes and which side reads. In playback the host fills the buffer and the engine drains it. In record the engine fills it and the host drains it. The buffer reports its free space in bytes and pulses an overflow flag. It also keeps a sticky threshold flag. In playback that flag means "room available" and in record it means "data waiting". Emptiness is held as a state bit of its own, so a completely full buffer, whose pointers are equal, is not mistaken for an empty one.

Top module: `nibble_fifo`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) leaves the buffer empty with `free_bytes` = 128 and `thr_flag`, `overflow`, `host_rdata` and `eng_rdata` all zero.
- R2: A host write in playback stores `host_wdata[7:4]` first and `host_wdata[3:0]` second. A host read in record returns two nibbles as a byte, with the earlier nibble in bits 7:4. Data leaves in the order it entered.
- R3: Writing an upper nibble while the buffer is not empty and the read byte pointer equals the write byte pointer raises `overflow` for exactly the following cycle. The nibble is still stored.
- R4: `free_bytes` is 128 when the buffer is empty. Otherwise it is (read byte pointer - write byte pointer) mod 128. It shows the state after the accesses of the previous clock edge.
- R5: A lower-nibble read that leaves the read pointer equal to the write pointer makes the buffer empty. The next upper-nibble write into an empty buffer restarts reading at the current write pointer.
- R6: `eng_fmt` selects the engine transfer size: 2'b00 moves 1 nibble, 2'b01 moves 2, and 2'b10 or 2'b11 moves 4. An engine write stores the low 4n bits of `eng_wdata`, most significant nibble first. An engine read returns its nibbles right-aligned in `eng_rdata`, with earlier nibbles more significant.
- R7: Reading from an empty buffer moves no pointer. Only the nibbles actually available are shifted into the result, so the missing nibbles appear as zeros above them.
- R8: With `rec_mode` = 0, `host_wr` writes and `eng_req` reads, and `host_rd` has no effect. With `rec_mode` = 1, `eng_req` writes and `host_rd` reads, and `host_wr` has no effect.
- R9: When a read and a write fall in the same cycle, the read is applied to the state before the write.
- R10: The threshold is (`thr_sel` + 1) x 16 bytes. It is tested only in cycles with `eng_req`, against the free space after that cycle's accesses. In playback `thr_flag` sets when free space > threshold. In record it sets when free space < threshold.
- R11: `thr_flag` holds until a cycle with `flag_clr` high and no new set condition. A set condition in the same cycle as `flag_clr` wins.
- R12: `host_rdata` and `eng_rdata` change only in the cycle after a read on their own port, and hold their value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rec_mode | input | 1 | 0 = playback (host writes), 1 = record (engine writes) |
| host_wr | input | 1 | Host byte write strobe (playback only) |
| host_wdata | input | 8 | Host write byte |
| host_rd | input | 1 | Host byte read strobe (record only) |
| host_rdata | output | 8 | Last byte read by the host |
| eng_req | input | 1 | Engine sample step: read in playback, write in record |
| eng_fmt | input | 2 | Engine nibble count code |
| eng_wdata | input | 16 | Engine write value, right-aligned |
| eng_rdata | output | 16 | Last engine read value, right-aligned |
| thr_sel | input | 3 | Threshold field |
| flag_clr | input | 1 | Clears the sticky threshold flag |
| thr_flag | output | 1 | Sticky threshold flag |
| overflow | output | 1 | One-cycle overflow pulse |
| empty | output | 1 | Buffer empty state |
| free_bytes | output | 8 | Free space in bytes |

## Verification
The two functions that can share a cycle are the read side and the write side: the host writing while the engine reads in playback, and the engine writing while the host reads in record. The bench provokes this on purpose in two cases. In one, the buffer holds a byte and the read returns that old byte, not the one being written. In the other, the buffer is empty and the read returns zero while the write still lands. A long pseudo-random run then drives both sides together with mode changes, flag clears and resets. Every output is compared each cycle against a byte-array model that applies the read before the write.

// File: rtl/nfifo_pkg.sv
package nfifo_pkg;
  localparam int NIB_MAX  = 4;
  localparam int NIB_BITS = 4;
  localparam int VAL_W    = NIB_MAX * NIB_BITS;
  localparam int CNT_W    = 3;

  typedef enum logic [1:0] {
    FMT_N1  = 2'b00,
    FMT_N2  = 2'b01,
    FMT_N4  = 2'b10,
    FMT_N4B = 2'b11
  } nib_fmt_e;

  // nibbles moved by one engine step
  function automatic logic [CNT_W-1:0] fmt_nibbles(nib_fmt_e f);
    case (f)
      FMT_N1:  return 3'd1;
      FMT_N2:  return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  // move the active nibbles of a right-aligned value to the top
  function automatic logic [VAL_W-1:0] left_align(logic [VAL_W-1:0] v, nib_fmt_e f);
    case (f)
      FMT_N1:  return {v[3:0], 12'h000};
      FMT_N2:  return {v[7:0], 8'h00};
      default: return v;
    endcase
  endfunction

  function automatic int unsigned space_bytes(logic is_empty, int unsigned rd,
                                              int unsigned wr, int unsigned depth);
    if (is_empty) return depth;
    return (rd + depth - wr) % depth;
  endfunction

  function automatic int unsigned thr_bytes(int unsigned sel, int unsigned step);
    return (sel + 1) * step;
  endfunction

  // playback wants room, record wants data
  function automatic logic thr_hit(logic rec, int unsigned space, int unsigned thr);
    return rec ? (space < thr) : (space > thr);
  endfunction
endpackage

// File: rtl/nfifo_store.sv
module nfifo_store
  import nfifo_pkg::*;
#(
  parameter int IDX_W = 8
) (
  input  logic                clk,
  input  logic [NIB_MAX-1:0]  wr_en,
  input  logic [IDX_W-1:0]    wr_base,
  input  logic [VAL_W-1:0]    wr_nibs,
  input  logic [IDX_W-1:0]    rd_base,
  output logic [VAL_W-1:0]    rd_nibs
);
  localparam int ENTRIES = 1 << IDX_W;

  // nibble k of a window sits at base + k; index = {byte, low-half}
  logic [NIB_BITS-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    for (int k = 0; k < NIB_MAX; k++) begin
      if (wr_en[k]) mem[wr_base + IDX_W'(k)] <= wr_nibs[VAL_W-1-NIB_BITS*k -: NIB_BITS];
    end
  end

  for (genvar g = 0; g < NIB_MAX; g++) begin : g_rd
    assign rd_nibs[VAL_W-1-NIB_BITS*g -: NIB_BITS] = mem[rd_base + IDX_W'(g)];
  end
endmodule

// File: rtl/nfifo_cursor.sv
module nfifo_cursor
  import nfifo_pkg::*;
#(
  parameter  int PTR_W = 7,
  localparam int IDX_W = PTR_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   rd_cnt,
  input  logic [CNT_W-1:0]   wr_cnt,
  input  logic [VAL_W-1:0]   wr_val,
  input  logic [VAL_W-1:0]   rd_nibs,
  output logic [VAL_W-1:0]   rd_val,
  output logic [IDX_W-1:0]   rd_base,
  output logic [IDX_W-1:0]   wr_base,
  output logic [NIB_MAX-1:0] wr_en,
  output logic               ovf_evt,
  output logic [PTR_W-1:0]   rptr_q,
  output logic [PTR_W-1:0]   wptr_q,
  output logic [PTR_W-1:0]   rptr_d,
  output logic [PTR_W-1:0]   wptr_d,
  output logic               empty_q,
  output logic               empty_d
);
  logic rph_q, wph_q, rph_d, wph_d;

  // read steps first on the old state, then write steps
  always_comb begin
    rptr_d  = rptr_q;
    rph_d   = rph_q;
    empty_d = empty_q;
    rd_val  = '0;
    for (int k = 0; k < NIB_MAX; k++) begin
      if (CNT_W'(k) < rd_cnt && !empty_d) begin
        rd_val = {rd_val[VAL_W-NIB_BITS-1:0], rd_nibs[VAL_W-1-NIB_BITS*k -: NIB_BITS]};
        if (rph_d) begin
          rptr_d = rptr_d + PTR_W'(1);
          rph_d  = 1'b0;
          if (rptr_d == wptr_q) empty_d = 1'b1;
        end else begin
          rph_d = 1'b1;
        end
      end
    end
    wptr_d  = wptr_q;
    wph_d   = wph_q;
    ovf_evt = 1'b0;
    for (int k = 0; k < NIB_MAX; k++) begin
      if (CNT_W'(k) < wr_cnt) begin
        if (!wph_d) begin
          if (empty_d) begin
            rptr_d  = wptr_d;
            rph_d   = 1'b0;
            empty_d = 1'b0;
          end else if (rptr_d == wptr_d) begin
            ovf_evt = 1'b1;
          end
          wph_d = 1'b1;
        end else begin
          wptr_d = wptr_d + PTR_W'(1);
          wph_d  = 1'b0;
        end
      end
    end
  end

  assign rd_base = {rptr_q, rph_q};
  assign wr_base = {wptr_q, wph_q};

  for (genvar g = 0; g < NIB_MAX; g++) begin : g_wen
    assign wr_en[g] = CNT_W'(g) < wr_cnt;
  end

  // wr_val is consumed by the store; kept here only for the window width
  logic unused_wr_val;
  assign unused_wr_val = ^wr_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr_q  <= '0;
      wptr_q  <= '0;
      rph_q   <= 1'b0;
      wph_q   <= 1'b0;
      empty_q <= 1'b1;
    end else begin
      rptr_q  <= rptr_d;
      wptr_q  <= wptr_d;
      rph_q   <= rph_d;
      wph_q   <= wph_d;
      empty_q <= empty_d;
    end
  end
endmodule

// File: rtl/nfifo_thresh.sv
module nfifo_thresh
  import nfifo_pkg::*;
#(
  parameter int FREE_W   = 8,
  parameter int THR_W    = 3,
  parameter int THR_STEP = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              rec,
  input  logic [FREE_W-1:0] space_nxt,
  input  logic [THR_W-1:0]  sel,
  input  logic              clr,
  output logic              flag
);
  logic set_evt;

  assign set_evt = step && thr_hit(rec, 32'(space_nxt), thr_bytes(32'(sel), THR_STEP));

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= set_evt | (flag & ~clr);
  end
endmodule

// File: rtl/nibble_fifo.sv
module nibble_fifo
  import nfifo_pkg::*;
#(
  parameter  int DEPTH_BYTES = 128,
  parameter  int THR_W       = 3,
  parameter  int THR_STEP    = 16,
  localparam int PTR_W       = $clog2(DEPTH_BYTES),
  localparam int IDX_W       = PTR_W + 1,
  localparam int FREE_W      = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rec_mode,
  input  logic              host_wr,
  input  logic [7:0]        host_wdata,
  input  logic              host_rd,
  output logic [7:0]        host_rdata,
  input  logic              eng_req,
  input  logic [1:0]        eng_fmt,
  input  logic [15:0]       eng_wdata,
  output logic [15:0]       eng_rdata,
  input  logic [THR_W-1:0]  thr_sel,
  input  logic              flag_clr,
  output logic              thr_flag,
  output logic              overflow,
  output logic              empty,
  output logic [FREE_W-1:0] free_bytes
);
  // named events for the checker
  logic wr_fire, rd_fire, ovf_evt;

  logic [CNT_W-1:0]   eng_n, wr_cnt, rd_cnt;
  logic [VAL_W-1:0]   wr_val, rd_val, rd_nibs;
  logic [IDX_W-1:0]   rd_base, wr_base;
  logic [NIB_MAX-1:0] wr_en;
  logic [PTR_W-1:0]   rptr_q, wptr_q, rptr_d, wptr_d;
  logic               empty_q, empty_d;
  logic [FREE_W-1:0]  space_nxt;

  assign eng_n   = fmt_nibbles(nib_fmt_e'(eng_fmt));
  assign wr_fire = rec_mode ? eng_req : host_wr;
  assign rd_fire = rec_mode ? host_rd : eng_req;
  assign wr_cnt  = !wr_fire ? '0 : (rec_mode ? eng_n : CNT_W'(2));
  assign rd_cnt  = !rd_fire ? '0 : (rec_mode ? CNT_W'(2) : eng_n);
  assign wr_val  = rec_mode ? left_align(eng_wdata, nib_fmt_e'(eng_fmt)) : {host_wdata, 8'h00};

  nfifo_store #(.IDX_W(IDX_W)) u_store (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_base (wr_base),
    .wr_nibs (wr_val),
    .rd_base (rd_base),
    .rd_nibs (rd_nibs)
  );

  nfifo_cursor #(.PTR_W(PTR_W)) u_cursor (
    .clk     (clk),
    .rst     (rst),
    .rd_cnt  (rd_cnt),
    .wr_cnt  (wr_cnt),
    .wr_val  (wr_val),
    .rd_nibs (rd_nibs),
    .rd_val  (rd_val),
    .rd_base (rd_base),
    .wr_base (wr_base),
    .wr_en   (wr_en),
    .ovf_evt (ovf_evt),
    .rptr_q  (rptr_q),
    .wptr_q  (wptr_q),
    .rptr_d  (rptr_d),
    .wptr_d  (wptr_d),
    .empty_q (empty_q),
    .empty_d (empty_d)
  );

  assign free_bytes = FREE_W'(space_bytes(empty_q, 32'(rptr_q), 32'(wptr_q), DEPTH_BYTES));
  assign space_nxt  = FREE_W'(space_bytes(empty_d, 32'(rptr_d), 32'(wptr_d), DEPTH_BYTES));
  assign empty      = empty_q;

  nfifo_thresh #(.FREE_W(FREE_W), .THR_W(THR_W), .THR_STEP(THR_STEP)) u_thresh (
    .clk       (clk),
    .rst       (rst),
    .step      (eng_req),
    .rec       (rec_mode),
    .space_nxt (space_nxt),
    .sel       (thr_sel),
    .clr       (flag_clr),
    .flag      (thr_flag)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      host_rdata <= '0;
      eng_rdata  <= '0;
      overflow   <= 1'b0;
    end else begin
      overflow <= ovf_evt;
      if (rd_fire) begin
        if (rec_mode) host_rdata <= rd_val[7:0];
        else          eng_rdata  <= rd_val;
      end
    end
  end
endmodule

// File: rtl/nibble_fifo_chk.sv
module nibble_fifo_chk #(
  parameter int DEPTH  = 128,
  parameter int FREE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              eng_req,
  input logic              flag_clr,
  input logic              thr_flag,
  input logic              overflow,
  input logic              empty,
  input logic [FREE_W-1:0] free_bytes,
  input logic              wr_fire,
  input logic              rd_fire
);
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> empty && !thr_flag && !overflow);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    overflow |-> $past(wr_fire));

  assert_free_range_R4: assert property (@(posedge clk) disable iff (rst)
    free_bytes <= FREE_W'(DEPTH));

  assert_idle_stable_R8: assert property (@(posedge clk) disable iff (rst)
    !wr_fire && !rd_fire |=> $stable(free_bytes) && $stable(empty));

  assert_empty_read_R7: assert property (@(posedge clk) disable iff (rst)
    rd_fire && !wr_fire && empty |=> empty && free_bytes == FREE_W'(DEPTH));

  assert_flag_source_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(thr_flag) |-> $past(eng_req));

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    thr_flag && !flag_clr |=> thr_flag);
endmodule

bind nibble_fifo nibble_fifo_chk #(.DEPTH(DEPTH_BYTES), .FREE_W(FREE_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .eng_req    (eng_req),
  .flag_clr   (flag_clr),
  .thr_flag   (thr_flag),
  .overflow   (overflow),
  .empty      (empty),
  .free_bytes (free_bytes),
  .wr_fire    (wr_fire),
  .rd_fire    (rd_fire)
);

// File: tb/nibble_fifo_bench.sv
`timescale 1ns/1ps
module nibble_fifo_bench;
  logic        clk = 1'b0;
  logic        rst, rec_mode, host_wr, host_rd, eng_req, flag_clr;
  logic [7:0]  host_wdata, host_rdata;
  logic [1:0]  eng_fmt;
  logic [15:0] eng_wdata, eng_rdata;
  logic [2:0]  thr_sel;
  logic        thr_flag, overflow, empty;
  logic [7:0]  free_bytes;

  always #2 clk = ~clk;

  nibble_fifo u_nibble_fifo (
    .clk(clk), .rst(rst), .rec_mode(rec_mode),
    .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd), .host_rdata(host_rdata),
    .eng_req(eng_req), .eng_fmt(eng_fmt), .eng_wdata(eng_wdata), .eng_rdata(eng_rdata),
    .thr_sel(thr_sel), .flag_clr(flag_clr), .thr_flag(thr_flag), .overflow(overflow),
    .empty(empty), .free_bytes(free_bytes)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // byte-array reference model
  logic [7:0]  m_mem [128];
  logic [6:0]  m_r, m_w;
  logic        m_rh, m_wh, m_empty, m_ovf, m_flag;
  logic [7:0]  m_hr;
  logic [15:0] m_er;

  function automatic int mfree();
    if (m_empty) return 128;
    return (int'(m_r) - int'(m_w)) & 127;
  endfunction

  function automatic int fmt_len(logic [1:0] f);
    return (f == 2'd0) ? 1 : (f == 2'd1) ? 2 : 4;
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    int nr, nw, val, thr;
    logic [3:0] wn [4];
    if (rst) begin
      m_r = '0; m_w = '0; m_rh = 0; m_wh = 0; m_empty = 1;
      m_ovf = 0; m_flag = 0; m_hr = '0; m_er = '0;
      return;
    end
    nr = 0; nw = 0;
    if (rec_mode) begin
      if (host_rd) nr = 2;
      if (eng_req) begin
        nw = fmt_len(eng_fmt);
        for (int i = 0; i < nw; i++) wn[i] = 4'((eng_wdata >> (4 * (nw - 1 - i))) & 16'hF);
      end
    end else begin
      if (eng_req) nr = fmt_len(eng_fmt);
      if (host_wr) begin
        nw = 2; wn[0] = host_wdata[7:4]; wn[1] = host_wdata[3:0];
      end
    end
    val = 0;
    for (int i = 0; i < nr; i++) begin
      if (!m_empty) begin
        val = (val << 4) | (m_rh ? int'(m_mem[m_r][3:0]) : int'(m_mem[m_r][7:4]));
        if (m_rh) begin
          m_r = m_r + 7'd1; m_rh = 0;
          if (m_r == m_w) m_empty = 1;
        end else m_rh = 1;
      end
    end
    m_ovf = 0;
    for (int i = 0; i < nw; i++) begin
      if (!m_wh) begin
        if (m_empty) begin m_r = m_w; m_empty = 0; end
        else if (m_r == m_w) m_ovf = 1;
        m_mem[m_w][7:4] = wn[i]; m_wh = 1;
      end else begin
        m_mem[m_w][3:0] = wn[i]; m_w = m_w + 7'd1; m_wh = 0;
      end
    end
    if (nr > 0) begin
      if (rec_mode) m_hr = 8'(val); else m_er = 16'(val);
    end
    thr = (int'(thr_sel) + 1) * 16;
    m_flag = (eng_req && (rec_mode ? mfree() < thr : mfree() > thr)) || (m_flag && !flag_clr);
  endtask

  task automatic compare();
    chk("R4 free_bytes", int'(free_bytes), mfree());
    chk("R5 empty", int'(empty), int'(m_empty));
    chk("R3 overflow", int'(overflow), int'(m_ovf));
    chk("R10 thr_flag", int'(thr_flag), int'(m_flag));
    chk("R6 eng_rdata", int'(eng_rdata), int'(m_er));
    chk("R2 host_rdata", int'(host_rdata), int'(m_hr));
  endtask

  task automatic tick();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare();
    host_wr = 0; host_rd = 0; eng_req = 0; flag_clr = 0; rst = 0;
  endtask

  task automatic do_reset(logic rec);
    rst = 1; rec_mode = rec; tick();
  endtask

  task automatic hw(logic [7:0] d);
    host_wr = 1; host_wdata = d; tick();
  endtask

  task automatic hr();
    host_rd = 1; tick();
  endtask

  task automatic eng(logic [1:0] f, logic [15:0] d);
    eng_req = 1; eng_fmt = f; eng_wdata = d; tick();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) m_mem[i] = '0;
    rst = 1; rec_mode = 0; host_wr = 0; host_rd = 0; eng_req = 0; flag_clr = 0;
    host_wdata = '0; eng_fmt = '0; eng_wdata = '0; thr_sel = 3'd7;
    @(negedge clk);
    rst = 1; tick();
    rst = 1; tick();
    // R1 reset state
    chk("R1 free", int'(free_bytes), 128);
    chk("R1 empty", int'(empty), 1);
    chk("R1 flag", int'(thr_flag), 0);
    chk("R1 ovf", int'(overflow), 0);
    chk("R1 rdata", int'(eng_rdata) + int'(host_rdata), 0);

    // fill every byte (mirrors memory into the model), then overrun
    for (int i = 0; i < 130; i++) begin
      hw(8'((i * 37 + 5) & 255));
      if (i == 127) chk("R4 full", int'(free_bytes), 0);
      if (i == 128) chk("R3 overflow on full", int'(overflow), 1);
    end
    idle_check: begin
      int fb;
      fb = int'(free_bytes);
      hr();
      chk("R8 host_rd ignored in playback free", int'(free_bytes), fb);
      chk("R8 host_rd ignored in playback data", int'(host_rdata), 0);
    end
    for (int i = 0; i < 40; i++) eng(2'(i % 4), 16'h0);

    // R6 formats, R7 empty reads
    do_reset(0);
    hw(8'hA5);
    eng(2'b10, 0);
    chk("R7 partial read right-aligned", int'(eng_rdata), 16'h00A5);
    chk("R5 empty after low read", int'(empty), 1);
    eng(2'b10, 0);
    chk("R7 empty read zero", int'(eng_rdata), 0);
    chk("R7 empty read no move", int'(free_bytes), 128);
    hw(8'h12); hw(8'h34);
    eng(2'b01, 0); chk("R6 two nibbles", int'(eng_rdata), 16'h12);
    eng(2'b00, 0); chk("R6 one nibble", int'(eng_rdata), 16'h3);
    eng(2'b00, 0); chk("R6 one nibble low", int'(eng_rdata), 16'h4);
    hw(8'hAB); hw(8'hCD);
    eng(2'b11, 0); chk("R6 four nibbles alt code", int'(eng_rdata), 16'hABCD);
    tick();
    chk("R12 read data holds", int'(eng_rdata), 16'hABCD);

    // R9 same-cycle read and write
    do_reset(0);
    hw(8'h3C);
    host_wr = 1; host_wdata = 8'h71; eng(2'b01, 0);
    chk("R9 read sees old byte", int'(eng_rdata), 16'h3C);
    chk("R9 free after swap", int'(free_bytes), 127);
    do_reset(0);
    host_wr = 1; host_wdata = 8'h5A; eng(2'b00, 0);
    chk("R9 read of empty before write", int'(eng_rdata), 0);
    chk("R9 write landed", int'(free_bytes), 127);
    eng(2'b01, 0);
    chk("R9 byte readable next", int'(eng_rdata), 16'h5A);

    // record mode
    do_reset(1);
    eng(2'b10, 16'hBEEF);
    chk("R6 four nibble write", int'(free_bytes), 126);
    hw(8'h11);
    chk("R8 host_wr ignored in record", int'(free_bytes), 126);
    hr(); chk("R2 host read first byte", int'(host_rdata), 8'hBE);
    hr(); chk("R2 host read second byte", int'(host_rdata), 8'hEF);
    eng(2'b00, 16'hFFF7); eng(2'b00, 16'h0009);
    hr(); chk("R6 one nibble writes combine", int'(host_rdata), 8'h79);
    hr(); chk("R7 host read empty", int'(host_rdata), 0);

    // threshold boundaries, both senses
    for (int s = 0; s < 8; s++) begin
      int thr;
      thr = (s + 1) * 16;
      thr_sel = 3'(s);
      do_reset(0);
      for (int j = 0; j < 129 - thr; j++) hw(8'(j));
      eng(2'b01, 0);
      chk("R10 playback at threshold", int'(thr_flag), 0);
      eng(2'b01, 0);
      chk("R10 playback above threshold", int'(thr_flag), (thr < 128) ? 1 : 0);
      do_reset(1);
      for (int j = 0; j < 128 - thr; j++) eng(2'b01, 16'(j));
      chk("R10 record at threshold", int'(thr_flag), 0);
      eng(2'b01, 16'h55);
      chk("R10 record below threshold", int'(thr_flag), 1);
    end

    // R11 clear and collision
    flag_clr = 1; tick();
    chk("R11 clear", int'(thr_flag), 0);
    flag_clr = 1; eng(2'b01, 16'h66);
    chk("R11 set wins over clear", int'(thr_flag), 1);
    tick();
    chk("R11 sticky", int'(thr_flag), 1);

    // pseudo-random mixed traffic
    begin
      logic [31:0] lf;
      lf = 32'h1ACE_B00C;
      for (int n = 0; n < 4000; n++) begin
        lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
        rst        = (lf[9:0] == 10'd0);
        if (lf[17:12] == 6'd0) rec_mode = ~rec_mode;
        host_wr    = lf[0];
        host_wdata = lf[15:8];
        host_rd    = lf[1];
        eng_req    = lf[2] & (lf[3] | lf[4]);
        eng_fmt    = lf[6:5];
        eng_wdata  = lf[31:16];
        if (lf[27:24] == 4'd0) thr_sel = lf[30:28];
        flag_clr   = lf[7] & lf[11];
        tick();
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule